// File: doc/BRIEF.md
# Full-Duplex Circular Sample Buffer Engine

This engine streams 8-bit audio samples between word memory and a codec port. A start command gives a base pointer. The engine reads a four-word header found at that base: the first and last output offsets, the starting offset and a signed input displacement. After that it runs one iteration for each sample tick at which the device is ready. Each 16-bit memory word carries two samples. An even iteration fetches an output word and stores one accumulated input word. An odd iteration writes the current position back to the header so that software can follow the engine. Outgoing and incoming data are both bitwise complemented. The pointer wraps from the last offset back to the first.

The memory port is a valid/ready request channel, and a read completes with a later `mem_rvalid` pulse. Once `mem_req_valid` is raised, the engine holds it and the address, direction and write data constant until `mem_req_ready` is seen. Only one read is in flight at a time. The codec exchange is also valid/ready. `xfer_valid` and `tx_sample` hold until `xfer_ready`, and `rx_sample` is taken in that same handshake cycle. The tick and command pins are plain single-cycle strobes. A start with an even pointer is taken only while stopped. A command with an odd pointer arms a stop, and the stop takes effect at the next tick.

Top module: `aud_ring_engine`

## Requirements
- R1: A start command with cmd_ptr bit 0 clear, issued while stopped, sets base = cmd_ptr with bits 1:0 cleared. It then issues exactly four reads, to base+0, base+1, base+2 and base+3, in that order, loading first, last, position and displacement.
- R2: Iterations alternate even and odd, and the first iteration after a start is even. An even iteration reads address base+pos and presents bits 15:8 of the complemented word as tx_sample.
- R3: An odd iteration writes pos to address base+2 and presents bits 7:0 of the complemented word from the preceding even iteration as tx_sample.
- R4: An even iteration writes the complement of the input accumulator to (base+pos+disp) mod 65536. Each exchange shifts rx_sample into the accumulator's low byte, so the older sample sits in the high byte. The accumulator clears at start, so the first word stored is 16'hFFFF.
- R5: At the end of an even iteration, pos becomes first if it equalled last, and pos+1 otherwise.
- R6: A tick with dev_ready low causes no memory or codec traffic and does not advance the even/odd phase.
- R7: A command with bit 0 set, issued while running, makes the next tick stop the engine without any traffic. Ticks while stopped cause no traffic.
- R8: A memory request holds valid, address, direction and data stable until accepted. No request is raised while a read is outstanding.
- R9: A codec exchange holds xfer_valid and tx_sample stable until accepted. It is never raised together with a memory request.
- R10: In an even iteration the read precedes the write. With zero displacement, the value read is the memory content from before that iteration's store.
- R11: A tick that arrives while an iteration is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ptr | input | 16 | Base pointer; bit 0 set requests stop |
| tick | input | 1 | Sample period strobe |
| dev_ready | input | 1 | Codec ready, sampled with tick |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 16 | Read data |
| xfer_valid | output | 1 | Codec exchange valid |
| xfer_ready | input | 1 | Codec exchange accepted |
| tx_sample | output | 8 | Outgoing sample |
| rx_sample | input | 8 | Incoming sample, taken at handshake |

## Verification
A wrong pointer or header field shows up at the next ready tick as a read or write at an unexpected address. A wrap error appears one tick after the last offset is reached. A corrupted accumulator or phase bit shows up in the data of the next even-iteration store, or in the byte lane chosen for tx_sample, within two ready ticks. A broken stop or ready check shows up as traffic in a window where the ports should stay quiet, so every tick is followed by a check for the exact number of handshakes.

// File: rtl/aud_ring_pkg.sv
package aud_ring_pkg;
  localparam int HDR_WORDS   = 4;
  localparam int HDR_POS_IDX = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_RUN,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_IN,
    ST_WR_POS,
    ST_XFER
  } aud_state_e;
endpackage

// File: rtl/aud_ring_ptr.sv
module aud_ring_ptr #(
  parameter int AW    = 16,
  parameter int IDX_W = 2
) (
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    first,
  input  logic [AW-1:0]    last,
  input  logic [AW-1:0]    pos,
  input  logic [AW-1:0]    disp,
  input  logic [IDX_W-1:0] hdr_idx,
  output logic [AW-1:0]    out_addr,
  output logic [AW-1:0]    in_addr,
  output logic [AW-1:0]    pos_addr,
  output logic [AW-1:0]    hdr_addr,
  output logic [AW-1:0]    pos_next
);
  import aud_ring_pkg::*;

  always_comb begin
    out_addr = base + pos;
    in_addr  = base + pos + disp;
    pos_addr = base + AW'(HDR_POS_IDX);
    hdr_addr = base + AW'(hdr_idx);
    pos_next = (pos == last) ? first : pos + AW'(1);
  end
endmodule

// File: rtl/aud_pack.sv
module aud_pack #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load_en,
  input  logic [DW-1:0] load_word,
  input  logic          shift_en,
  input  logic [DW/2-1:0] rx,
  input  logic          low_half,
  output logic [DW/2-1:0] tx,
  output logic [DW-1:0] store_word
);
  localparam int SW = DW / 2;

  logic [DW-1:0] oword_q;
  logic [DW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oword_q <= '0;
      acc_q   <= '0;
    end else begin
      if (load_en) oword_q <= ~load_word;
      if (clear) acc_q <= '0;
      else if (shift_en) acc_q <= {acc_q[SW-1:0], rx};
    end
  end

  always_comb begin
    tx         = low_half ? oword_q[SW-1:0] : oword_q[DW-1:SW];
    store_word = ~acc_q;
  end
endmodule

// File: rtl/aud_ring_engine.sv
module aud_ring_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [ADDR_W-1:0]   cmd_ptr,
  input  logic                tick,
  input  logic                dev_ready,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                xfer_valid,
  input  logic                xfer_ready,
  output logic [DATA_W/2-1:0] tx_sample,
  input  logic [DATA_W/2-1:0] rx_sample
);
  import aud_ring_pkg::*;

  localparam int IDX_W = $clog2(HDR_WORDS);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(HDR_WORDS - 1);

  aud_state_e        state_q;
  logic [ADDR_W-1:0] base_q, first_q, last_q, pos_q, disp_q;
  logic [IDX_W-1:0]  idx_q;
  logic              odd_q;
  logic              stop_q;

  logic [ADDR_W-1:0] out_addr, in_addr, pos_addr, hdr_addr, pos_next;
  logic [DATA_W-1:0] store_word;
  logic              mem_hs, xfer_hs, start_cmd, load_en;

  aud_ring_ptr #(.AW(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .base(base_q), .first(first_q), .last(last_q), .pos(pos_q), .disp(disp_q),
    .hdr_idx(idx_q), .out_addr(out_addr), .in_addr(in_addr),
    .pos_addr(pos_addr), .hdr_addr(hdr_addr), .pos_next(pos_next)
  );

  aud_pack #(.DW(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(start_cmd), .load_en(load_en),
    .load_word(mem_rdata), .shift_en(xfer_hs), .rx(rx_sample),
    .low_half(odd_q), .tx(tx_sample), .store_word(store_word)
  );

  always_comb begin
    start_cmd     = (state_q == ST_IDLE) && cmd_valid && !cmd_ptr[0];
    load_en       = (state_q == ST_RD_WAIT) && mem_rvalid;
    mem_req_valid = (state_q == ST_HDR_REQ) || (state_q == ST_RD_REQ) ||
                    (state_q == ST_WR_IN)   || (state_q == ST_WR_POS);
    mem_we        = (state_q == ST_WR_IN) || (state_q == ST_WR_POS);
    xfer_valid    = (state_q == ST_XFER);
    mem_hs        = mem_req_valid && mem_req_ready;
    xfer_hs       = xfer_valid && xfer_ready;
    case (state_q)
      ST_HDR_REQ: mem_addr = hdr_addr;
      ST_RD_REQ:  mem_addr = out_addr;
      ST_WR_IN:   mem_addr = in_addr;
      ST_WR_POS:  mem_addr = pos_addr;
      default:    mem_addr = '0;
    endcase
    case (state_q)
      ST_WR_IN:  mem_wdata = store_word;
      ST_WR_POS: mem_wdata = DATA_W'(pos_q);
      default:   mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
      pos_q   <= '0;
      disp_q  <= '0;
      idx_q   <= '0;
      odd_q   <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && cmd_valid && cmd_ptr[0]) stop_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          stop_q <= 1'b0;
          if (start_cmd) begin
            base_q  <= cmd_ptr & ALIGN_MASK;
            idx_q   <= '0;
            odd_q   <= 1'b0;
            state_q <= ST_HDR_REQ;
          end
        end
        ST_HDR_REQ: if (mem_hs) state_q <= ST_HDR_WAIT;
        ST_HDR_WAIT: if (mem_rvalid) begin
          case (idx_q)
            IDX_W'(0): first_q <= ADDR_W'(mem_rdata);
            IDX_W'(1): last_q  <= ADDR_W'(mem_rdata);
            IDX_W'(2): pos_q   <= ADDR_W'(mem_rdata);
            default:   disp_q  <= ADDR_W'(mem_rdata);
          endcase
          if (idx_q == IDX_W'(HDR_WORDS - 1)) state_q <= ST_RUN;
          else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_HDR_REQ;
          end
        end
        ST_RUN: if (tick) begin
          if (stop_q) begin
            stop_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (dev_ready) begin
            state_q <= odd_q ? ST_WR_POS : ST_RD_REQ;
          end
        end
        ST_RD_REQ:  if (mem_hs) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid) state_q <= ST_WR_IN;
        ST_WR_IN:   if (mem_hs) state_q <= ST_XFER;
        ST_WR_POS:  if (mem_hs) state_q <= ST_XFER;
        ST_XFER: if (xfer_hs) begin
          if (!odd_q) pos_q <= pos_next;
          odd_q   <= ~odd_q;
          state_q <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aud_ring_checker.sv
module aud_ring_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                mem_rvalid,
  input logic                xfer_valid,
  input logic                xfer_ready,
  input logic [DATA_W/2-1:0] tx_sample
);
  logic rd_open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_open_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_we) rd_open_q <= 1'b1;
    else if (mem_rvalid) rd_open_q <= 1'b0;
  end

  AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open_q |-> !mem_req_valid); // R8

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) &&
    $stable(mem_we) && $stable(mem_wdata)); // R8

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(tx_sample)); // R9

  AST_XFER_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_valid && mem_req_valid)); // R9
endmodule

bind aud_ring_engine aud_ring_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready), .tx_sample(tx_sample)
);

// File: tb/aud_ring_engine_test.sv
module aud_ring_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_valid, tick, dev_ready;
  logic [15:0] cmd_ptr;
  logic mem_req_valid, mem_req_ready, mem_we, mem_rvalid;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic xfer_valid, xfer_ready;
  logic [7:0] tx_sample, rx_sample;

  aud_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ptr(cmd_ptr),
    .tick(tick), .dev_ready(dev_ready), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .tx_sample(tx_sample),
    .rx_sample(rx_sample)
  );

  logic [15:0] mem [0:255];
  logic [32:0] mlog [$];
  logic [15:0] xlog [$];
  int total = 0;
  int bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_next(logic [15:0] p, logic [15:0] f, logic [15:0] l);
    return (p == l) ? f : p + 16'd1;
  endfunction

  function automatic logic [15:0] f_in_addr(logic [15:0] b, logic [15:0] p, logic [15:0] d);
    return b + p + d;
  endfunction

  // memory model
  logic pend;
  logic [1:0] lat;
  logic [15:0] rd_hold;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata <= '0;
      pend <= 1'b0;
      lat <= '0;
    end else begin
      mem_req_ready <= ($urandom % 4) != 0;
      mem_rvalid <= 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata <= rd_hold;
          pend <= 1'b0;
        end else lat <= lat - 2'd1;
      end
      if (mem_req_valid && mem_req_ready) begin
        mlog.push_back({mem_we, mem_addr, mem_we ? mem_wdata : 16'h0});
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else begin
          pend <= 1'b1;
          lat <= 2'($urandom % 3);
          rd_hold <= mem[mem_addr[7:0]];
        end
      end
    end
  end

  // codec model
  always @(posedge clk) begin
    if (!rst_n) begin
      xfer_ready <= 1'b0;
      rx_sample <= '0;
    end else begin
      xfer_ready <= ($urandom % 3) != 0;
      rx_sample <= 8'($urandom);
      if (xfer_valid && xfer_ready) xlog.push_back({tx_sample, rx_sample});
    end
  end

  // reference state
  logic [15:0] base_m, first_m, last_m, pos_m, disp_m, acc_m, oword_m;
  logic odd_m, run_m, stop_m, fresh_m;

  task automatic start_buf(logic [15:0] p, logic [15:0] f, logic [15:0] l,
                           logic [15:0] s, logic [15:0] d);
    logic [15:0] b;
    b = p & 16'hFFFC;
    mem[b[7:0]] = f; mem[8'(b + 1)] = l; mem[8'(b + 2)] = s; mem[8'(b + 3)] = d;
    mlog.delete(); xlog.delete();
    @(negedge clk); cmd_valid = 1'b1; cmd_ptr = p;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk("R1 header read count", mlog.size(), 4);
    for (int i = 0; i < 4 && i < mlog.size(); i++)
      chk("R1 header read order", mlog[i], {1'b0, b + 16'(i), 16'h0});
    base_m = b; first_m = f; last_m = l; pos_m = s; disp_m = d;
    acc_m = 16'h0; odd_m = 1'b0; run_m = 1'b1; stop_m = 1'b0; fresh_m = 1'b1;
  endtask

  task automatic do_tick(logic rdy, logic hold);
    logic [15:0] snap, oa;
    oa = base_m + pos_m;
    snap = mem[oa[7:0]];
    mlog.delete(); xlog.delete();
    @(negedge clk); tick = 1'b1; dev_ready = rdy;
    if (hold) @(negedge clk);
    @(negedge clk); tick = 1'b0; dev_ready = 1'b0;
    repeat (100) @(negedge clk);
    if (!run_m || stop_m) begin
      chk("R7 no memory traffic when stopping/stopped", mlog.size(), 0);
      chk("R7 no codec traffic when stopping/stopped", xlog.size(), 0);
      run_m = 1'b0; stop_m = 1'b0;
    end else if (!rdy) begin
      chk("R6 not ready: memory quiet", mlog.size(), 0);
      chk("R6 not ready: codec quiet", xlog.size(), 0);
    end else if (!odd_m) begin
      chk(hold ? "R11 even handshakes (tick held)" : "R8 even mem handshakes", mlog.size(), 2);
      chk(hold ? "R11 even exchanges (tick held)" : "R9 even exchanges", xlog.size(), 1);
      if (mlog.size() == 2 && xlog.size() == 1) begin
        chk("R2 even read address", mlog[0], {1'b0, oa, 16'h0});
        chk(disp_m == 0 ? "R10 store after read, same word" : "R4 input store",
            mlog[1], {1'b1, f_in_addr(base_m, pos_m, disp_m), ~acc_m});
        if (fresh_m) chk("R4 first store is all ones", mlog[1][15:0], 16'hFFFF);
        oword_m = ~snap;
        chk(disp_m == 0 ? "R10 high sample from pre-store word" : "R2 high sample",
            xlog[0][15:8], oword_m[15:8]);
        acc_m = {acc_m[7:0], xlog[0][7:0]};
      end
      fresh_m = 1'b0;
      pos_m = f_next(pos_m, first_m, last_m);
      odd_m = 1'b1;
    end else begin
      chk(hold ? "R11 odd handshakes (tick held)" : "R8 odd mem handshakes", mlog.size(), 1);
      chk("R9 odd exchanges", xlog.size(), 1);
      if (mlog.size() == 1 && xlog.size() == 1) begin
        chk("R3/R5 position write-back", mlog[0], {1'b1, base_m + 16'd2, pos_m});
        chk("R3 low sample", xlog[0][15:8], oword_m[7:0]);
        acc_m = {acc_m[7:0], xlog[0][7:0]};
      end
      odd_m = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_ptr = '0; tick = 1'b0; dev_ready = 1'b0;
    run_m = 1'b0; stop_m = 1'b0;
    base_m = '0; first_m = '0; last_m = '0; pos_m = '0; disp_m = '0;
    acc_m = '0; oword_m = '0; odd_m = 1'b0; fresh_m = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    repeat (4) @(negedge clk);
    chk("R8 reset: no memory request", mem_req_valid, 0);
    chk("R9 reset: no exchange", xfer_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_tick(1'b1, 1'b0);                                  // R7 idle tick
    start_buf(16'h0082, 16'd4, 16'd9, 16'd7, 16'hFF90);   // R1 alignment, R4 wrap mod 2^16
    do_tick(1'b0, 1'b0);                                  // R6
    for (int k = 0; k < 40; k++)
      do_tick(($urandom % 4) != 0, (k == 10 || k == 11)); // R2 R3 R4 R5 R11
    @(negedge clk); cmd_valid = 1'b1; cmd_ptr = 16'h0081;
    @(negedge clk); cmd_valid = 1'b0;
    stop_m = 1'b1;
    do_tick(1'b1, 1'b0);                                  // R7 stopping tick
    do_tick(1'b1, 1'b0);                                  // R7 stopped
    start_buf(16'h0040, 16'd4, 16'd5, 16'd4, 16'd0);      // R10 coincident buffers
    for (int k = 0; k < 10; k++) do_tick(1'b1, 1'b0);
    finish_run();
  end
endmodule